// File: doc/BRIEF.md
# Remote DMA Read-Port Handshake Controller

This block moves a run of bytes out of a local buffer memory to a host through an external output latch, one byte at a time. Configuration gives it a start address, a byte count and a one-cycle start pulse. The block then runs a local memory read cycle and pulses a port-write strobe so the latch captures the byte on the local data bus. It then waits until the host acknowledges that it has taken the latched byte before it fetches the next one. The block acts only as a slave: it drives the local buffer address and the memory read strobe, and never drives host-side addresses. The latch takes its data directly from the local data bus, so no data passes through the block.

Every memory cycle is a four-phase sequence timed by the bus clock. T1 presents the address. T2, T3 and T4 hold the read strobe. The port-write strobe is high during T4. The ready input is sampled at the end of T3, and each clock it is found low inserts one wait phase (TW) between T3 and T4. The first read follows the start pulse at once, which primes the latch. Every later read is started by a rising edge of the asynchronous read acknowledge, after that edge has passed a two-flop synchronizer.

States: IDLE, T1, T2, T3, TW, T4, WACK (wait for acknowledge), DONE. Transitions:
- IDLE→T1 on start with a nonzero count.
- IDLE→DONE on start with a zero count.
- T1→T2 and T2→T3 always.
- T3→T4 and TW→T4 when ready is high.
- T3→TW and TW→TW when ready is low.
- T4→WACK when bytes remain, and T4→DONE after the last byte.
- WACK→T1 on a synchronized acknowledge edge.
- DONE→IDLE always.

Top module: `rdport_dma_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, mem_rd, port_wr, busy and done are all 0.
- R2: A start pulse with a nonzero count puts the block in T1 on the next cycle with no acknowledge needed. busy=1, mem_rd=0 and mem_addr equals the start address.
- R3: With ready high, a memory cycle lasts exactly four clocks (T1..T4). mem_rd is 0 in T1 and 1 for the three clocks after it, and mem_addr stays stable for the whole cycle.
- R4: Ready is sampled at the end of T3 and in each wait phase. Each clock edge that finds ready low delays T4 by one clock, with mem_rd held at 1 and port_wr at 0.
- R5: port_wr is 1 for exactly one clock, in T4, and only while mem_rd is 1. On the next clock both port_wr and mem_rd are 0.
- R6: After a byte that is not the last, no new read starts until a fresh rising edge of the acknowledge input. An acknowledge held high causes exactly one refill.
- R7: On the third clock edge after the first edge that samples the acknowledge high, the block enters T1. mem_rd rises on the fourth edge.
- R8: The local address increments by one after each completed cycle, wrapping modulo 2^AW, and the remaining count decrements by one.
- R9: After the T4 of the last byte, done is 1 for exactly one clock and busy is 0. No further read occurs.
- R10: A start with count 0 issues no read and gives a one-clock done pulse on the next cycle.
- R11: A start pulse while a transfer is active is ignored. The running address and count are kept.
- R12: An acknowledge edge while idle starts no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock timing the memory cycle phases |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | One-cycle pulse that starts a transfer |
| cfg_addr | input | AW | First local buffer address |
| cfg_count | input | CW | Number of bytes to move |
| ready | input | 1 | High lets the cycle finish; low inserts a wait phase |
| host_rack | input | 1 | Asynchronous host acknowledge that the latch was read |
| mem_addr | output | AW | Local buffer address |
| mem_rd | output | 1 | Local memory read strobe (T2..T4) |
| port_wr | output | 1 | Latch load strobe; its rising edge marks valid data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse at transfer end |

## Verification
The checks take for granted that cfg_start is a single-cycle pulse, and that host_rack stays low long enough between acknowledges for the synchronizer to settle low, so that each acknowledge yields a clean edge. The bench drives every input one nanosecond after a rising edge. It lowers host_rack and waits several clocks before each new acknowledge. Ready is held either steadily high or low for a whole number of clocks, so it is always stable when the controller samples it.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4,
        ST_WACK,
        ST_DONE
    } rdp_state_e;
endpackage

// File: rtl/rdport_ack_sync.sv
module rdport_ack_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/rdport_xfer_cnt.sv
module rdport_xfer_cnt #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= ld_addr;
            left_q <= ld_count;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            left_q <= left_q - CNT_ONE;
        end
    end

    assign addr = addr_q;
    assign last = (left_q == CNT_ONE);
endmodule

// File: rtl/rdport_dma_ctrl.sv
module rdport_dma_ctrl
    import rdport_pkg::*;
#(
    parameter int AW          = 16,
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          ready,
    input  logic          host_rack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          port_wr,
    output logic          busy,
    output logic          done
);
    rdp_state_e state, nxt;
    logic       ack_rise;
    logic       last;
    logic       load;
    logic       step;

    rdport_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (host_rack),
        .rise     (ack_rise)
    );

    assign load = (state == ST_IDLE) && cfg_start;
    assign step = (state == ST_T4);

    rdport_xfer_cnt #(.AW(AW), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ld_addr  (cfg_addr),
        .ld_count (cfg_count),
        .step     (step),
        .addr     (mem_addr),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (cfg_start) nxt = (cfg_count == '0) ? ST_DONE : ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ready ? ST_T4 : ST_TW;
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4:   nxt = last ? ST_DONE : ST_WACK;
            ST_WACK: if (ack_rise) nxt = ST_T1;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_rd  = 1'b0;
        port_wr = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_T1:   ;
            ST_T2,
            ST_T3,
            ST_TW:   mem_rd = 1'b1;
            ST_T4: begin
                mem_rd  = 1'b1;
                port_wr = 1'b1;
            end
            ST_WACK: ;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdport_dma_chk.sv
module rdport_dma_chk
    import rdport_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input rdp_state_e    state,
    input logic          ready,
    input logic          ack_rise,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          port_wr,
    input logic          busy,
    input logic          done
);
    p_t1_to_t2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T1 |=> state == ST_T2);
    p_t2_to_t3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T2 |=> state == ST_T3);
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !port_wr) |=> $stable(mem_addr));
    p_wait_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && !ready) |=> state == ST_TW);
    p_go_t4_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && ready) |=> state == ST_T4);
    p_wr_in_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |-> mem_rd);
    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (!port_wr && !mem_rd));
    p_hold_wack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WACK && !ack_rise) |=> state == ST_WACK);
    p_ack_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WACK && ack_rise) |=> state == ST_T1);
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> mem_addr == AW'($past(mem_addr) + AW'(1)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy && !mem_rd));
endmodule

bind rdport_dma_ctrl rdport_dma_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .ready    (ready),
    .ack_rise (ack_rise),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .port_wr  (port_wr),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_rdport_dma_ctrl.sv
`timescale 1ns/1ps
module tb_rdport_dma_ctrl;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_start;
    logic [AW-1:0] cfg_addr;
    logic [CW-1:0] cfg_count;
    logic          ready;
    logic          host_rack;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          port_wr;
    logic          busy;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rdport_dma_ctrl #(.AW(AW), .CW(CW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_start (cfg_start),
        .cfg_addr  (cfg_addr),
        .cfg_count (cfg_count),
        .ready     (ready),
        .host_rack (host_rack),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .port_wr   (port_wr),
        .busy      (busy),
        .done      (done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual run=%0d cycles expected end earlier", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic start_xfer(input logic [AW-1:0] a, input logic [CW-1:0] c);
        cfg_addr  = a;
        cfg_count = c;
        cfg_start = 1'b1;
        tick();
        cfg_start = 1'b0;
    endtask

    // entry: block in T1 of a cycle for address ea
    task automatic byte_cycle(input logic [AW-1:0] ea, input int waits, input bit is_last);
        chk(mem_addr == ea, "R8", "address in T1", 32'(mem_addr), 32'(ea));
        chk(!mem_rd && !port_wr && busy, "R3", "T1 strobes {rd,wr,busy}",
            {29'd0, mem_rd, port_wr, busy}, 32'b001);
        ready = 1'b1;
        tick();
        chk(mem_rd && !port_wr, "R3", "T2 {rd,wr}", {30'd0, mem_rd, port_wr}, 32'b10);
        if (waits > 0) ready = 1'b0;
        tick();
        chk(mem_rd && !port_wr, "R3", "T3 {rd,wr}", {30'd0, mem_rd, port_wr}, 32'b10);
        for (int w = 0; w < waits; w++) begin
            tick();
            chk(mem_rd && !port_wr && mem_addr == ea, "R4", "wait phase {rd,wr}",
                {30'd0, mem_rd, port_wr}, 32'b10);
        end
        ready = 1'b1;
        tick();
        chk(port_wr && mem_rd && mem_addr == ea, "R5", "T4 {rd,wr}",
            {30'd0, mem_rd, port_wr}, 32'b11);
        tick();
        chk(!port_wr && !mem_rd, "R5", "after T4 {rd,wr}", {30'd0, mem_rd, port_wr}, 32'b00);
        if (is_last) begin
            chk(done && !busy, "R9", "end {done,busy}", {30'd0, done, busy}, 32'b10);
            tick();
            chk(!done && !busy && !mem_rd, "R9", "after done {done,busy,rd}",
                {29'd0, done, busy, mem_rd}, 32'b000);
        end else begin
            chk(!done && busy, "R6", "waiting {done,busy}", {30'd0, done, busy}, 32'b01);
        end
    endtask

    task automatic give_ack(input bit hold);
        host_rack = 1'b1;
        tick();
        chk(!mem_rd && busy, "R7", "edge1 {rd,busy}", {30'd0, mem_rd, busy}, 32'b01);
        tick();
        chk(!mem_rd && busy, "R7", "edge2 {rd,busy}", {30'd0, mem_rd, busy}, 32'b01);
        tick();
        if (!hold) host_rack = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0; cfg_start = 1'b0; cfg_addr = '0; cfg_count = '0;
        ready = 1'b1; host_rack = 1'b0;
        repeat (3) tick();
        chk(!mem_rd && !port_wr && !busy && !done, "R1", "in reset {rd,wr,busy,done}",
            {28'd0, mem_rd, port_wr, busy, done}, 32'b0);
        rst_n = 1'b1;
        tick();
        chk(!mem_rd && !port_wr && !busy && !done, "R1", "after reset {rd,wr,busy,done}",
            {28'd0, mem_rd, port_wr, busy, done}, 32'b0);
    endtask

    task automatic test_basic();
        start_xfer(16'h0100, 16'd3);
        chk(busy && !mem_rd && mem_addr == 16'h0100, "R2", "primed first read addr",
            32'(mem_addr), 32'h0100);
        byte_cycle(16'h0100, 0, 1'b0);
        repeat (5) tick();
        chk(!mem_rd && busy, "R6", "no read without ack", {30'd0, mem_rd, busy}, 32'b01);
        give_ack(1'b0);
        byte_cycle(16'h0101, 0, 1'b0);
        repeat (3) tick();
        give_ack(1'b0);
        byte_cycle(16'h0102, 0, 1'b1);
    endtask

    task automatic test_wait();
        repeat (4) tick();
        start_xfer(16'h0340, 16'd2);
        byte_cycle(16'h0340, 2, 1'b0);
        repeat (3) tick();
        give_ack(1'b0);
        byte_cycle(16'h0341, 1, 1'b1);
    endtask

    task automatic test_held_ack();
        repeat (4) tick();
        start_xfer(16'h0500, 16'd3);
        byte_cycle(16'h0500, 0, 1'b0);
        repeat (3) tick();
        give_ack(1'b1);
        byte_cycle(16'h0501, 0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk(!mem_rd && busy, "R6", "held ack no second refill",
                {30'd0, mem_rd, busy}, 32'b01);
        end
        host_rack = 1'b0;
        repeat (4) tick();
        give_ack(1'b0);
        byte_cycle(16'h0502, 0, 1'b1);
        host_rack = 1'b1;
        repeat (6) tick();
        chk(!mem_rd && !busy, "R9", "ack after done no read", {30'd0, mem_rd, busy}, 32'b00);
        host_rack = 1'b0;
        repeat (4) tick();
    endtask

    task automatic test_zero();
        start_xfer(16'h0900, 16'd0);
        chk(done && !busy && !mem_rd, "R10", "zero count {done,busy,rd}",
            {29'd0, done, busy, mem_rd}, 32'b100);
        tick();
        chk(!done && !mem_rd && !busy, "R10", "zero count after {done,busy,rd}",
            {29'd0, done, busy, mem_rd}, 32'b000);
    endtask

    task automatic test_restart_ignored();
        repeat (3) tick();
        start_xfer(16'h0200, 16'd2);
        byte_cycle(16'h0200, 0, 1'b0);
        start_xfer(16'h0700, 16'd5);
        chk(!mem_rd && busy && mem_addr == 16'h0201, "R11", "start while busy addr",
            32'(mem_addr), 32'h0201);
        repeat (2) tick();
        give_ack(1'b0);
        byte_cycle(16'h0201, 0, 1'b1);
    endtask

    task automatic test_idle_ack();
        repeat (3) tick();
        host_rack = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(!mem_rd && !busy, "R12", "idle ack no read", {30'd0, mem_rd, busy}, 32'b00);
        end
        host_rack = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!mem_rd && !busy, "R12", "idle after ack", {30'd0, mem_rd, busy}, 32'b00);
        end
    endtask

    task automatic test_wrap();
        start_xfer(16'hFFFF, 16'd2);
        byte_cycle(16'hFFFF, 0, 1'b0);
        chk(mem_addr == 16'h0000, "R8", "address wrap", 32'(mem_addr), 32'h0000);
        repeat (3) tick();
        give_ack(1'b0);
        byte_cycle(16'h0000, 0, 1'b1);
    endtask

    initial begin
        test_reset();
        test_basic();
        test_wait();
        test_held_ack();
        test_zero();
        test_restart_ignored();
        test_idle_ack();
        test_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule